// File: doc/BRIEF.md
# Panel Strobe Delay Generator

This block sits after an LCD timing controller and derives the auxiliary panel strobes from that controller's horizontal sync. When sync falls, a line sequence starts. After a programmable number of dot-clock periods, the block raises the latch pulse (`lp_o`), drops the power-save strobe (`ps_o`) and raises the clear strobe (`cls_o`) together, and toggles the polarity-reversal output (`rev_o`). The modulation output (`mod_o`) is driven low at each line start. It goes high after a programmable number of rising edges on the `sps_i` input.

A single 32-bit timing register holds the delay fields. Each field holds the required count minus one. Bits 3:0 are the latch delay, bits 7:4 the reversal delay, bits 11:8 the shared power-save/clear delay and bits 13:12 the modulation hold count. Bits 31:14 are reserved.

Two small state machines run the block. The line machine has the states `ST_IDLE`, `ST_COUNT` and `ST_HOLD`:
- It moves from `ST_IDLE` to `ST_COUNT` on a detected sync fall.
- It moves from `ST_COUNT` to `ST_HOLD` once the longest delay has fired.
- It returns to `ST_IDLE` from `ST_COUNT` or from `ST_HOLD` on a detected sync rise.

The modulation machine has the states `MS_IDLE`, `MS_LOW` and `MS_HIGH`:
- A sync fall sends it from any state to `MS_LOW`.
- It moves from `MS_LOW` to `MS_HIGH` on the final counted SPS edge.

Top module: `panel_strobe_gen`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00001000: the modulation field in bits 13:12 is 01 and every other bit is 0.
- R2: A write stores bits 13:0, and `reg_rdata` returns them. Bits 31:14 ignore writes and always read 0.
- R3: Suppose `hsync_i` goes low in the cycle before rising edge k. With SYNC_STAGES=2 and an effective latch field f, `lp_o` rises at edge k+2+f.
- R4: With an effective field f in bits 11:8, `ps_o` falls and `cls_o` rises on the same edge, k+2+f.
- R5: With an effective field f in bits 7:4, `rev_o` inverts at edge k+2+f and otherwise keeps its level.
- R6: A delay field programmed to 0 or 1 acts as 2, so the shortest delay is 3 clocks.
- R7: A detected rise of `hsync_i` returns `lp_o` low, `ps_o` high and `cls_o` low. Strobes of that line that have not fired yet are cancelled.
- R8: Only a high-to-low transition of sync starts a sequence. Holding sync low does not restart any counter, so `rev_o` changes once per line.
- R9: At each line start `mod_o` goes low. It goes high after field+1 rising edges of `sps_i`, counted from that start.
- R10: A register write made during a line leaves that line's delays unchanged. The new values apply from the next sync fall.
- R11: After reset `ps_o` is high and `cls_o`, `lp_o`, `rev_o` and `mod_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read-back value |
| hsync_i | input | 1 | Horizontal sync from the timing controller |
| sps_i | input | 1 | SPS pulse input counted by the modulation logic |
| ps_o | output | 1 | Power-save strobe, idle high |
| cls_o | output | 1 | Clear strobe, idle low |
| rev_o | output | 1 | Polarity-reversal output |
| lp_o | output | 1 | Line latch pulse |
| mod_o | output | 1 | Modulation output |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer and a minimum delay of three clocks. With these values each strobe edge falls on one computable dot-clock edge, so every cycle of a line can be compared. The 4-bit fields reach the full span from the clamped values 0 and 1 up to 15, which is the sixteen-clock maximum. The 2-bit modulation field reaches all four hold counts. Random field mixes place the three strobes in every relative order, including coincident edges.

// File: rtl/pstrobe_pkg.sv
package pstrobe_pkg;
    localparam int DLY_W = 4;
    localparam int MOD_W = 2;
    localparam int CFG_W = 3 * DLY_W + MOD_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } line_state_t;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_LOW  = 2'd1,
        MS_HIGH = 2'd2
    } mod_state_t;

    typedef struct packed {
        logic [MOD_W-1:0] mod_hold;
        logic [DLY_W-1:0] ps_dly;
        logic [DLY_W-1:0] rev_dly;
        logic [DLY_W-1:0] lp_dly;
    } timing_cfg_t;
endpackage

// File: rtl/pstrobe_sync.sv
module pstrobe_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= RST_VAL;
            end else if (g == 0) begin
                chain[g] <= d;
            end else begin
                chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pstrobe_reg.sv
module pstrobe_reg
    import pstrobe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output timing_cfg_t cfg,
    output logic [31:0] rdata
);
    localparam logic [MOD_W-1:0] MOD_RST = 1;

    logic unused_rsv;
    assign unused_rsv = ^wdata[31:CFG_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg          <= '0;
            cfg.mod_hold <= MOD_RST;
        end else if (wr) begin
            cfg <= timing_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    assign rdata = {{(32-CFG_W){1'b0}}, cfg};
endmodule

// File: rtl/pstrobe_line_fsm.sv
module pstrobe_line_fsm
    import pstrobe_pkg::*;
#(
    parameter int MIN_CLOCKS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hs_fall,
    input  logic        hs_rise,
    input  timing_cfg_t cfg,
    output line_state_t state,
    output logic        ps_o,
    output logic        cls_o,
    output logic        rev_o,
    output logic        lp_o
);
    localparam logic [DLY_W-1:0] MIN_FIELD = DLY_W'(MIN_CLOCKS - 1);

    line_state_t      state_nx;
    logic [DLY_W-1:0] elapsed;
    logic [DLY_W-1:0] lp_snap, rev_snap, ps_snap, last_snap;

    function automatic logic [DLY_W-1:0] eff(input logic [DLY_W-1:0] f);
        return (f < MIN_FIELD) ? MIN_FIELD : f;
    endfunction

    always_comb begin
        last_snap = lp_snap;
        if (rev_snap > last_snap) last_snap = rev_snap;
        if (ps_snap > last_snap)  last_snap = ps_snap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (hs_fall) state_nx = ST_COUNT;
            ST_COUNT: begin
                if (hs_rise)                     state_nx = ST_IDLE;
                else if (elapsed == last_snap)   state_nx = ST_HOLD;
            end
            ST_HOLD:  if (hs_rise) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_o     <= 1'b1;
            cls_o    <= 1'b0;
            rev_o    <= 1'b0;
            lp_o     <= 1'b0;
            elapsed  <= '0;
            lp_snap  <= MIN_FIELD;
            rev_snap <= MIN_FIELD;
            ps_snap  <= MIN_FIELD;
        end else begin
            if (hs_fall) begin
                elapsed  <= DLY_W'(1);
                lp_snap  <= eff(cfg.lp_dly);
                rev_snap <= eff(cfg.rev_dly);
                ps_snap  <= eff(cfg.ps_dly);
            end else if (state == ST_COUNT && !hs_rise) begin
                elapsed <= elapsed + 1'b1;
                if (elapsed == lp_snap) lp_o <= 1'b1;
                if (elapsed == rev_snap) rev_o <= ~rev_o;
                if (elapsed == ps_snap) begin
                    ps_o  <= 1'b0;
                    cls_o <= 1'b1;
                end
            end
            if (hs_rise) begin
                lp_o  <= 1'b0;
                ps_o  <= 1'b1;
                cls_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pstrobe_mod_ctrl.sv
module pstrobe_mod_ctrl
    import pstrobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sps_rise,
    input  logic [MOD_W-1:0] hold_field,
    output mod_state_t       state,
    output logic             mod_o
);
    mod_state_t       state_nx;
    logic [MOD_W-1:0] seen;
    logic [MOD_W-1:0] hold_snap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MS_IDLE: if (start) state_nx = MS_LOW;
            MS_LOW: begin
                if (start)                              state_nx = MS_LOW;
                else if (sps_rise && seen == hold_snap) state_nx = MS_HIGH;
            end
            MS_HIGH: if (start) state_nx = MS_LOW;
            default: state_nx = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_o     <= 1'b0;
            seen      <= '0;
            hold_snap <= '0;
        end else begin
            mod_o <= (state_nx == MS_HIGH);
            if (start) begin
                seen      <= '0;
                hold_snap <= hold_field;
            end else if (state == MS_LOW && sps_rise) begin
                seen <= seen + 1'b1;
            end
        end
    end
endmodule

// File: rtl/panel_strobe_gen.sv
module panel_strobe_gen
    import pstrobe_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CLOCKS  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        hsync_i,
    input  logic        sps_i,
    output logic        ps_o,
    output logic        cls_o,
    output logic        rev_o,
    output logic        lp_o,
    output logic        mod_o
);
    timing_cfg_t cfg;
    line_state_t line_state;
    mod_state_t  mod_state;
    logic        hs_sync, sps_sync, hs_prev, sps_prev;
    logic        hs_fall, hs_rise, sps_rise;

    pstrobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hs_sync (
        .clk(clk), .rst_n(rst_n), .d(hsync_i), .q(hs_sync));

    pstrobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sps_sync (
        .clk(clk), .rst_n(rst_n), .d(sps_i), .q(sps_sync));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_prev  <= 1'b1;
            sps_prev <= 1'b0;
        end else begin
            hs_prev  <= hs_sync;
            sps_prev <= sps_sync;
        end
    end

    assign hs_fall  = hs_prev & ~hs_sync;
    assign hs_rise  = ~hs_prev & hs_sync;
    assign sps_rise = ~sps_prev & sps_sync;

    pstrobe_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .cfg(cfg), .rdata(reg_rdata));

    pstrobe_line_fsm #(.MIN_CLOCKS(MIN_CLOCKS)) u_line (
        .clk(clk), .rst_n(rst_n), .hs_fall(hs_fall), .hs_rise(hs_rise),
        .cfg(cfg), .state(line_state), .ps_o(ps_o), .cls_o(cls_o),
        .rev_o(rev_o), .lp_o(lp_o));

    pstrobe_mod_ctrl u_mod (
        .clk(clk), .rst_n(rst_n), .start(hs_fall), .sps_rise(sps_rise),
        .hold_field(cfg.mod_hold), .state(mod_state), .mod_o(mod_o));
endmodule

// File: rtl/panel_strobe_chk.sv
module panel_strobe_chk
    import pstrobe_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        ps_o,
    input logic        cls_o,
    input logic        rev_o,
    input logic        lp_o,
    input logic        mod_o,
    input logic        hs_fall,
    input line_state_t line_state
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:14] == 18'h0); // R2

    AST_PS_CLS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps_o) |-> $rose(cls_o)); // R4

    AST_LP_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_o) |-> $past(line_state) == ST_COUNT); // R3

    AST_REV_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rev_o) |-> $past(line_state) == ST_COUNT); // R5

    AST_MOD_DROP_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_o) |-> $past(hs_fall)); // R9

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        line_state == ST_IDLE |-> (ps_o && !cls_o && !lp_o)); // R7
endmodule

bind panel_strobe_gen panel_strobe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .ps_o(ps_o),
    .cls_o(cls_o), .rev_o(rev_o), .lp_o(lp_o), .mod_o(mod_o),
    .hs_fall(hs_fall), .line_state(line_state));

// File: tb/panel_strobe_gen_tb.sv
`timescale 1ns/1ps
module panel_strobe_gen_tb;
    localparam int S = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hsync_i = 1'b1;
    logic        sps_i = 1'b0;
    logic        ps_o, cls_o, rev_o, lp_o, mod_o;

    int compared = 0;
    int mismatched = 0;
    logic rev_m = 1'b0;

    always #2.5 clk = ~clk;

    panel_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hsync_i(hsync_i), .sps_i(sps_i),
        .ps_o(ps_o), .cls_o(cls_o), .rev_o(rev_o), .lp_o(lp_o), .mod_o(mod_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff(input logic [3:0] f);
        return (f < 4'd2) ? 2 : int'(f);
    endfunction

    function automatic logic [31:0] pack(input logic [1:0] m, input logic [3:0] p,
                                         input logic [3:0] r, input logic [3:0] l);
        return {18'h0, m, p, r, l};
    endfunction

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // One full line; mid=1 writes nd at cycle 3 (R10: must not affect this line)
    task automatic run_line(input logic [3:0] lpf, input logic [3:0] revf,
                            input logic [3:0] psf, input bit mid, input logic [31:0] nd);
        int tl, tr, tp;
        tl = S + eff(lpf); tr = S + eff(revf); tp = S + eff(psf);
        @(negedge clk);
        hsync_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R3 lp", lp_o, (i >= tl));
            chk("R4 ps", ps_o, !(i >= tp));
            chk("R4 cls", cls_o, (i >= tp));
            chk("R5 rev", rev_o, rev_m ^ (i >= tr));
            if (mid && i == 3) begin reg_wr = 1'b1; reg_wdata = nd; end
            if (i == 4) reg_wr = 1'b0;
        end
        rev_m = ~rev_m;
        repeat (6) @(negedge clk);
        chk("R8 rev held while sync low", rev_o, rev_m);
        chk("R8 lp held while sync low", lp_o, 1'b1);
        hsync_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 lp idle", lp_o, 1'b0);
        chk("R7 ps idle", ps_o, 1'b1);
        chk("R7 cls idle", cls_o, 1'b0);
    endtask

    task automatic mod_line(input logic [1:0] m);
        reg_write(pack(m, 4'd2, 4'd2, 4'd2));
        @(negedge clk);
        hsync_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R9 mod low at line start", mod_o, 1'b0);
        for (int p = 0; p <= int'(m); p++) begin
            sps_i = 1'b1;
            repeat (3) @(negedge clk);
            sps_i = 1'b0;
            repeat (3) @(negedge clk);
            chk("R9 mod level after sps edge", mod_o, (p == int'(m)));
        end
        repeat (10) @(negedge clk);
        chk("R9 mod stays high", mod_o, 1'b1);
        hsync_i = 1'b1;
        rev_m = ~rev_m;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset reg", reg_rdata, 32'h0000_1000);
        chk("R11 reset ps", ps_o, 1'b1);
        chk("R11 reset cls", cls_o, 1'b0);
        chk("R11 reset lp", lp_o, 1'b0);
        chk("R11 reset rev", rev_o, 1'b0);
        chk("R11 reset mod", mod_o, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reg after release", reg_rdata, 32'h0000_1000);

        reg_write(32'hFFFF_FFFF);
        chk("R2 reserved ignore", reg_rdata, 32'h0000_3FFF);
        rv = $urandom();
        reg_write(rv);
        chk("R2 readback", reg_rdata, {18'h0, rv[13:0]});

        // R6 clamp of small fields
        reg_write(pack(2'd0, 4'd0, 4'd1, 4'd0));
        run_line(4'd0, 4'd1, 4'd0, 1'b0, 32'h0);
        // maximum delays
        reg_write(pack(2'd3, 4'd15, 4'd15, 4'd15));
        run_line(4'd15, 4'd15, 4'd15, 1'b0, 32'h0);
        // R10 mid-line write
        reg_write(pack(2'd1, 4'd9, 4'd3, 4'd12));
        run_line(4'd12, 4'd3, 4'd9, 1'b1, pack(2'd0, 4'd4, 4'd14, 4'd6));
        chk("R10 new value visible", reg_rdata, pack(2'd0, 4'd4, 4'd14, 4'd6));
        run_line(4'd6, 4'd14, 4'd4, 1'b0, 32'h0);

        // R7 abort: sync rises before any strobe fires
        reg_write(pack(2'd0, 4'd15, 4'd15, 4'd15));
        @(negedge clk);
        hsync_i = 1'b0;
        repeat (6) @(negedge clk);
        hsync_i = 1'b1;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            chk("R7 abort lp", lp_o, 1'b0);
            chk("R7 abort ps", ps_o, 1'b1);
            chk("R7 abort rev", rev_o, rev_m);
        end

        for (int m = 0; m < 4; m++) mod_line(2'(m));

        for (int n = 0; n < 12; n++) begin
            rv = $urandom();
            reg_write(rv);
            run_line(rv[3:0], rv[7:4], rv[11:8], 1'b0, 32'h0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule